// File: doc/BRIEF.md
# Frame-Aligned Controlled Slip Buffer

This block is an elastic store for one framed TDM byte channel. It moves the channel from a line-side write clock to a system-side read clock. The write side stores time-slot bytes into frame-sized slots, starting a slot only on a byte flagged as frame start. The read side hands out bytes whenever the system timing pulls them. When the two rates drift apart, the block corrects the difference only at a read frame boundary. It either plays the current frame again or jumps over one whole stored frame. Bytes within a frame are therefore never lost or duplicated one at a time.

The write side counts completed frames. That count crosses to the read clock as a Gray code through a synchronizer chain. At the end of each read frame, the read side compares this count against the frame it would read next and makes its slip decision. After reset, the read pointer sits half the buffer behind the write pointer. A replay or a skip moves the fill back toward the middle, so a steady rate offset gives regularly spaced slips. Two sticky status flags record the slips. Software clears each flag with a write-one-to-clear pulse.

Both streaming edges use valid/ready. The store never stalls the line: `in_ready` is high whenever the block is out of reset, and a byte counts as written on any cycle with `in_valid` high. `out_valid` is high whenever the block is out of reset. A pulse of `out_ready` pulls one byte, and `out_data` and `out_sof` describe the byte pulled on that cycle. Holding `out_ready` low has the same effect as slowing the read rate. The storage tolerates this only until the write side has wrapped around the buffer.

Top module: `frame_slip_buffer`

## Requirements
- R1: Outside reset, `in_ready` is 1. While the write side waits for a frame start, a byte with `in_sof`=0 is dropped. Until the first `in_sof` after reset, the write side is waiting.
- R2: A byte with `in_sof`=1 that arrives in the middle of a frame restarts the same slot at byte 0. The cut-short frame is never delivered.
- R3: A slot counts as a complete frame only after its byte at position FRAME_LEN-1 has been written.
- R4: Outside reset, `out_valid` is 1. Each cycle with `out_valid` and `out_ready` both high advances the read position by one byte, and `out_sof` is 1 exactly at byte position 0.
- R5: The read side changes frame only after the handshake on byte FRAME_LEN-1. Every delivered frame is a whole frame with its bytes in written order.
- R6: At a frame end, if the frame that follows is not yet complete (zero complete frames ahead), the current frame is played again and `unf_flag` sets.
- R7: At a frame end, if NUM_FRAMES-1 or more complete frames lie ahead, one whole frame is skipped and `ovf_flag` sets.
- R8: When the write and read rates are equal, no slip occurs and the delivered frames follow one another in write order.
- R9: Each flag is sticky until a one-cycle clear pulse on its own clear input. A clear pulse does not affect the other flag. A slip in the same cycle as a clear leaves the flag set.
- R10: After reset, both flags are 0 and the read position is at byte 0 of a slot NUM_FRAMES/2 frames behind the write side.
- R11: A steady rate offset produces repeated slips rather than a stuck state. At least two slips of the same kind occur over a run of thirty frames.
- R12: The synchronized write-frame count changes by at most one bit per read clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_w | input | 1 | Line-side write clock |
| clk_r | input | 1 | System-side read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| in_valid | input | 1 | Write byte present |
| in_sof | input | 1 | Write byte is byte 0 of a frame |
| in_data | input | DATA_W | Write byte |
| in_ready | output | 1 | Store accepts bytes (high outside reset) |
| out_valid | output | 1 | Read byte available (high outside reset) |
| out_ready | input | 1 | System pulls the presented byte |
| out_data | output | DATA_W | Presented read byte |
| out_sof | output | 1 | Presented byte is byte 0 of a frame |
| ovf_clr | input | 1 | Clear pulse for the overflow flag (read clock) |
| unf_clr | input | 1 | Clear pulse for the underflow flag (read clock) |
| ovf_flag | output | 1 | Sticky: a frame was skipped |
| unf_flag | output | 1 | Sticky: a frame was replayed |

## Verification
The bench builds the block with FRAME_LEN=8 and NUM_FRAMES=4, which is 32 bytes of storage. A frame then passes in a few dozen read cycles, so thirty-frame runs stay short. At a write-to-read rate ratio of 0.8 or 1.33, several replays or skips occur within one run. That makes the periodic re-centring and both flags reachable many times over. Each byte carries a frame tag and its position, so the bench can classify every delivered frame as the next one, a replay, a skip or a torn frame. Stray bytes before the first frame start and a frame cut short by an early frame start show up as foreign tags if they ever leak through.

// File: rtl/slip_buf_pkg.sv
package slip_buf_pkg;

  localparam int GRAY_MAX_W = 16;

  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPLAY = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_e;

  function automatic logic [GRAY_MAX_W-1:0] to_gray(input logic [GRAY_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GRAY_MAX_W-1:0] from_gray(input logic [GRAY_MAX_W-1:0] g);
    logic [GRAY_MAX_W-1:0] b;
    b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
    for (int i = GRAY_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/slip_wr_side.sv
module slip_wr_side
  import slip_buf_pkg::*;
#(
  parameter int FRAME_LEN  = 32,
  parameter int NUM_FRAMES = 4,
  parameter int DATA_W     = 8
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              in_valid,
  input  logic                                              in_sof,
  input  logic [DATA_W-1:0]                                 in_data,
  output logic                                              in_ready,
  output logic                                              mem_we,
  output logic [$clog2(NUM_FRAMES)+$clog2(FRAME_LEN)-1:0]   mem_addr,
  output logic [DATA_W-1:0]                                 mem_wdata,
  output logic [$clog2(NUM_FRAMES):0]                       frm_gray
);
  localparam int BW = $clog2(FRAME_LEN);
  localparam int SW = $clog2(NUM_FRAMES);
  localparam int PW = SW + 1;

  logic          ready_q;
  logic [BW-1:0] wbyte;      // 0 means waiting for a frame start
  logic [PW-1:0] wfrm;       // completed-frame count
  logic [PW-1:0] wfrm_inc;
  logic [PW-1:0] wfrm_gray;
  logic          take_sof, take_body, last_body;
  logic [BW-1:0] wr_pos;

  assign take_sof  = in_valid && ready_q && in_sof;
  assign take_body = in_valid && ready_q && !in_sof && (wbyte != '0);
  assign last_body = take_body && (wbyte == BW'(FRAME_LEN - 1));
  assign wfrm_inc  = wfrm + PW'(1);
  assign wr_pos    = take_sof ? '0 : wbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      wbyte     <= '0;
      wfrm      <= '0;
      wfrm_gray <= '0;
    end else begin
      ready_q <= 1'b1;
      if (take_sof)       wbyte <= BW'(1);
      else if (take_body) wbyte <= last_body ? '0 : wbyte + BW'(1);
      if (last_body) begin
        wfrm      <= wfrm_inc;
        wfrm_gray <= PW'(to_gray(GRAY_MAX_W'(wfrm_inc)));
      end
    end
  end

  assign in_ready  = ready_q;
  assign mem_we    = take_sof || take_body;
  assign mem_addr  = {wfrm[SW-1:0], wr_pos};
  assign mem_wdata = in_data;
  assign frm_gray  = wfrm_gray;

  // R1: a byte without frame start while waiting is dropped
  assert_stray_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && wbyte == '0) |=> (wbyte == '0 && $stable(wfrm)));

  // R2: a frame start always restarts the current slot at byte 0
  assert_sof_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> (wbyte == BW'(1) && $stable(wfrm)));

  // R3: the frame count only moves on the last byte of a slot
  assert_commit_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !in_sof && wbyte == BW'(FRAME_LEN - 1)) |=> $stable(wfrm));

endmodule

// File: rtl/slip_gray_sync.sv
module slip_gray_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

  // R12: a Gray-coded count steps by at most one bit per clock
  assert_gray_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q ^ $past(q)) <= 1);

endmodule

// File: rtl/slip_rd_side.sv
module slip_rd_side
  import slip_buf_pkg::*;
#(
  parameter int FRAME_LEN  = 32,
  parameter int NUM_FRAMES = 4
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic [$clog2(NUM_FRAMES):0]                     wr_frm_gray_s,
  input  logic                                            out_ready,
  output logic                                            out_valid,
  output logic                                            out_sof,
  output logic [$clog2(NUM_FRAMES)+$clog2(FRAME_LEN)-1:0] rd_addr,
  input  logic                                            ovf_clr,
  input  logic                                            unf_clr,
  output logic                                            ovf_flag,
  output logic                                            unf_flag
);
  localparam int BW        = $clog2(FRAME_LEN);
  localparam int SW        = $clog2(NUM_FRAMES);
  localparam int PW        = SW + 1;
  localparam int START_LAG = NUM_FRAMES / 2;
  localparam int DROP_AT   = NUM_FRAMES - 1;

  logic          valid_q;
  logic [BW-1:0] rbyte;
  logic [PW-1:0] rfrm;
  logic [PW-1:0] wr_frm_s, nxt_frm, ahead;
  logic          hs, frame_end;
  slip_e         decision;

  assign wr_frm_s  = PW'(from_gray(GRAY_MAX_W'(wr_frm_gray_s)));
  assign nxt_frm   = rfrm + PW'(1);
  assign ahead     = wr_frm_s - nxt_frm;
  assign hs        = valid_q && out_ready;
  assign frame_end = hs && (rbyte == BW'(FRAME_LEN - 1));

  always_comb begin
    if (ahead == '0)                 decision = SLIP_REPLAY;
    else if (ahead >= PW'(DROP_AT))  decision = SLIP_DROP;
    else                             decision = SLIP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      rbyte    <= '0;
      rfrm     <= PW'(2 * NUM_FRAMES - START_LAG);
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      if (hs) rbyte <= frame_end ? '0 : rbyte + BW'(1);
      if (frame_end) begin
        unique case (decision)
          SLIP_REPLAY: rfrm <= rfrm;
          SLIP_DROP:   rfrm <= rfrm + PW'(2);
          default:     rfrm <= nxt_frm;
        endcase
      end
      ovf_flag <= (frame_end && decision == SLIP_DROP)   || (ovf_flag && !ovf_clr);
      unf_flag <= (frame_end && decision == SLIP_REPLAY) || (unf_flag && !unf_clr);
    end
  end

  assign out_valid = valid_q;
  assign out_sof   = (rbyte == '0);
  assign rd_addr   = {rfrm[SW-1:0], rbyte};

  // R4: each handshake inside a frame moves one byte on
  assert_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !frame_end) |=> (rbyte == $past(rbyte) + BW'(1)));

  // R5: the read frame never changes away from a frame end
  assert_boundary_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(rfrm));

  // R6: nothing complete ahead -> same frame again, underflow flagged
  assert_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ahead == '0) |=> ($stable(rfrm) && unf_flag));

  // R7: buffer nearly full -> one frame skipped, overflow flagged
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ahead >= PW'(DROP_AT)) |=> (rfrm == $past(rfrm) + PW'(2) && ovf_flag));

  // R8: fill in the normal band -> plain advance
  assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ahead != '0 && ahead < PW'(DROP_AT)) |=> (rfrm == $past(rfrm) + PW'(1)));

  // R9: flags hold until their own clear pulse
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !unf_clr) |=> unf_flag);

endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer #(
  parameter int FRAME_LEN   = 32,
  parameter int NUM_FRAMES  = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  input  logic              ovf_clr,
  input  logic              unf_clr,
  output logic              ovf_flag,
  output logic              unf_flag
);
  localparam int BW    = $clog2(FRAME_LEN);
  localparam int SW    = $clog2(NUM_FRAMES);
  localparam int PW    = SW + 1;
  localparam int AW    = SW + BW;
  localparam int DEPTH = 1 << AW;

  logic              mem_we;
  logic [AW-1:0]     mem_waddr, rd_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [PW-1:0]     frm_gray_w, frm_gray_r;
  logic [DATA_W-1:0] store [DEPTH];

  slip_wr_side #(.FRAME_LEN(FRAME_LEN), .NUM_FRAMES(NUM_FRAMES), .DATA_W(DATA_W)) u_wr (
    .clk(clk_w), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_waddr), .mem_wdata(mem_wdata),
    .frm_gray(frm_gray_w)
  );

  slip_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_r), .rst_n(rst_n), .d(frm_gray_w), .q(frm_gray_r)
  );

  slip_rd_side #(.FRAME_LEN(FRAME_LEN), .NUM_FRAMES(NUM_FRAMES)) u_rd (
    .clk(clk_r), .rst_n(rst_n),
    .wr_frm_gray_s(frm_gray_r),
    .out_ready(out_ready), .out_valid(out_valid), .out_sof(out_sof),
    .rd_addr(rd_addr),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  always_ff @(posedge clk_w) begin
    if (mem_we) store[mem_waddr] <= mem_wdata;
  end

  assign out_data = store[rd_addr];

endmodule

// File: tb/test_frame_slip_buffer.sv
`timescale 1ns/1ps
module test_frame_slip_buffer;
  localparam int FL  = 8;
  localparam int NF  = 4;
  localparam int IDS = 14;   // frame tags 0..13; 14/15 mark foreign bytes

  logic clk_w = 1'b0, clk_r = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_ready;
  logic [7:0] in_data = '0, out_data;
  logic out_valid, out_ready = 1'b0, out_sof;
  logic ovf_clr = 1'b0, unf_clr = 1'b0, ovf_flag, unf_flag;

  always #3 clk_w = ~clk_w;
  always #4 clk_r = ~clk_r;   // 125 MHz

  frame_slip_buffer #(.FRAME_LEN(FL), .NUM_FRAMES(NF), .DATA_W(8)) i_frame_slip_buffer (
    .clk_w(clk_w), .clk_r(clk_r), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int checks = 0, errors = 0;
  int wr_gap = 8;
  bit wr_en = 0, stray_req = 0, trunc_req = 0;
  int rep_cnt, skip_cnt, bad_cnt, alien_cnt, sof_err, seen, prev_id;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic s);
    @(negedge clk_w); in_valid = 1'b1; in_data = d; in_sof = s;
    @(negedge clk_w); in_valid = 1'b0; in_sof = 1'b0;
    repeat (wr_gap - 2) @(negedge clk_w);
  endtask

  // line-side source: tagged frames, optional stray and cut-short frames
  initial begin
    int wid;
    wid = 0;
    forever begin
      if (!wr_en) begin
        wid = 0;
        @(negedge clk_w);
      end else begin
        if (stray_req) begin stray_req = 0; put(8'hEE, 1'b0); put(8'hEF, 1'b0); end
        if (trunc_req) begin trunc_req = 0; put(8'hE0, 1'b1); put(8'hE1, 1'b0); put(8'hE2, 1'b0); end
        for (int b = 0; b < FL; b++) put(8'(wid * 16 + b), b == 0);
        wid = (wid + 1) % IDS;
      end
    end
  end

  task automatic restart(input int wg);
    wr_en = 0; out_ready = 1'b0;
    repeat (100) @(negedge clk_r);
    rst_n = 1'b0; wr_gap = wg;
    rep_cnt = 0; skip_cnt = 0; bad_cnt = 0; alien_cnt = 0; sof_err = 0; seen = 0; prev_id = -1;
    repeat (4) @(negedge clk_r);
    rst_n = 1'b1; wr_en = 1;
  endtask

  task automatic read_frames(input int n, input int gap);
    for (int f = 0; f < n; f++) begin
      logic [7:0] fb [FL];
      bit ok;
      int id, d;
      for (int b = 0; b < FL; b++) begin
        @(negedge clk_r); out_ready = 1'b1;
        fb[b] = out_data;
        if (out_sof != (b == 0)) sof_err++;
        @(negedge clk_r); out_ready = 1'b0;
        repeat (gap - 2) @(negedge clk_r);
      end
      seen++;
      if (seen > NF / 2) begin   // first frames come from unwritten slots
        ok = 1;
        for (int b = 0; b < FL; b++) begin
          if (fb[b][7:4] >= 4'(IDS)) alien_cnt++;
          if (fb[b][3:0] != 4'(b) || fb[b][7:4] != fb[0][7:4]) ok = 0;
        end
        id = int'(fb[0][7:4]);
        if (!ok || id >= IDS) begin
          bad_cnt++;
          prev_id = -1;
        end else begin
          if (prev_id >= 0) begin
            d = (id - prev_id + IDS) % IDS;
            if (d == 0) rep_cnt++;
            else if (d == 2) skip_cnt++;
            else if (d != 1) bad_cnt++;
          end
          prev_id = id;
        end
      end
    end
  endtask

  task automatic pulse_clr(input bit o, input bit u);
    @(negedge clk_r); ovf_clr = o; unf_clr = u;
    @(negedge clk_r); ovf_clr = 1'b0; unf_clr = 1'b0;
    @(negedge clk_r);
  endtask

  task automatic test_reset();
    restart(8);
    wr_en = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk_r);
    check(in_ready == 1'b0 && out_valid == 1'b0, "R4 held in reset", {in_ready, out_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_r);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b1 && out_sof == 1'b1, "R10 read at byte 0", {out_valid, out_sof}, 3);
    check(ovf_flag == 1'b0 && unf_flag == 1'b0, "R10 flags clear", {ovf_flag, unf_flag}, 0);
  endtask

  task automatic test_equal_rates();
    restart(8);
    read_frames(20, 6);
    check(sof_err == 0, "R4 out_sof position", sof_err, 0);
    check(bad_cnt == 0, "R5 whole ordered frames", bad_cnt, 0);
    // R12: a correct crossing gives a steady fill, hence no slip
    check(rep_cnt == 0 && skip_cnt == 0, "R8 no slip at equal rates", rep_cnt + skip_cnt, 0);
    check(ovf_flag == 1'b0 && unf_flag == 1'b0, "R8 R12 flags quiet", {ovf_flag, unf_flag}, 0);
  endtask

  task automatic test_slow_writer();
    restart(10);
    read_frames(30, 6);
    check(bad_cnt == 0 && sof_err == 0, "R5 frames intact under replay", bad_cnt + sof_err, 0);
    check(unf_flag == 1'b1, "R6 underflow flag", unf_flag, 1);
    check(skip_cnt == 0 && ovf_flag == 1'b0, "R6 no skip when slow", skip_cnt + ovf_flag, 0);
    check(rep_cnt >= 2, "R11 periodic replays", rep_cnt, 2);
  endtask

  task automatic test_fast_writer();
    restart(6);
    read_frames(30, 6);
    check(bad_cnt == 0 && sof_err == 0, "R5 frames intact under skip", bad_cnt + sof_err, 0);
    check(ovf_flag == 1'b1, "R7 overflow flag", ovf_flag, 1);
    check(rep_cnt == 0 && unf_flag == 1'b0, "R7 no replay when fast", rep_cnt + unf_flag, 0);
    check(skip_cnt >= 2, "R11 periodic skips", skip_cnt, 2);
  endtask

  task automatic test_flag_clear();
    // reader is halted, so no new decision can set a flag
    pulse_clr(1'b0, 1'b1);
    check(ovf_flag == 1'b1, "R9 unf_clr leaves ovf_flag", ovf_flag, 1);
    pulse_clr(1'b1, 1'b0);
    check(ovf_flag == 1'b0, "R9 ovf_clr clears", ovf_flag, 0);
    repeat (20) @(negedge clk_r);
    check(ovf_flag == 1'b0 && unf_flag == 1'b0, "R9 stays clear", {ovf_flag, unf_flag}, 0);
  endtask

  task automatic test_framing();
    stray_req = 1;
    restart(8);
    read_frames(8, 6);
    trunc_req = 1;
    read_frames(12, 6);
    check(alien_cnt == 0, "R1 R2 stray and cut-short bytes never delivered", alien_cnt, 0);
    check(bad_cnt == 0 && sof_err == 0, "R3 only complete frames delivered", bad_cnt + sof_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_r);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_equal_rates();
    test_slow_writer();
    test_fast_writer();
    test_flag_clear();
    test_framing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule